// File: doc/BRIEF.md
# Signed Fractional Multiply-Accumulate Unit

This unit keeps a running sum of products, c(n) = a(n)·b + c(n−1). A coefficient b is captured once into a holding register. After that, every cycle that carries a valid sample a(n) adds the product of the two values into a 16-bit accumulator. Both operands are 8-bit two's-complement numbers, and the 8×8 product is 16 bits wide.

A mode input picks how the product is read. In integer mode the raw signed product is added. In fractional mode both operands are treated as 1.7 values. The product is shifted left by one bit so that it becomes a 1.15 value, and its upper byte is then a 1.7 result.

The block fits inside filter, regulator or transform datapaths. A controller there clears the sum, feeds one sample per step and reads the accumulator.

Top module: `frac_mac`

## Requirements
- R1: After reset, acc_out is 0x0000 and the held coefficient is 0, so a valid sample leaves acc_out at 0x0000 until a coefficient is loaded.
- R2: With frac_mode = 0 and smp_valid = 1, the next acc_out equals the previous acc_out plus the signed product smp_in × coefficient, sign-extended to 16 bits. The result is visible one clock edge after the sample.
- R3: With frac_mode = 1 and smp_valid = 1, the added term is the signed product shifted left by one bit and truncated to 16 bits.
- R4: In fractional mode, 0x80 × 0x80 adds 0x8000 (wrap, no saturation).
- R5: Accumulator overflow wraps modulo 2^16 and raises no flag.
- R6: clr = 1 sets acc_out to 0x0000 at the next edge, even when smp_valid is high in the same cycle.
- R7: When smp_valid = 0 and clr = 0, acc_out does not change, whatever smp_in and frac_mode carry.
- R8: coef_load = 1 captures coef_in at the edge, and the value is held until the next load. A sample accepted in the same cycle as a load uses the previously held coefficient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| coef_load | input | 1 | Capture coef_in into the coefficient register |
| coef_in | input | 8 | Coefficient b, signed |
| frac_mode | input | 1 | 0 = integer product, 1 = fractional 1.7 × 1.7 product |
| smp_valid | input | 1 | Sample strobe; one accumulate per high cycle |
| smp_in | input | 8 | Sample a(n), signed |
| clr | input | 1 | Synchronous clear of the accumulator, wins over smp_valid |
| acc_out | output | 16 | Registered accumulator value |

## Verification
A sample, a clear or a coefficient load presented before a rising edge has its effect at that edge. acc_out therefore shows a sample's contribution, or the cleared value, one edge after the stimulus. A new coefficient first enters a product at the edge after the load.

The bench drives inputs on the falling edge and keeps its own arithmetic model of the sum. It advances that model at the rising edge and compares acc_out a short delay after the same edge, before the next inputs are applied. After reset, it waits the two synchronizer cycles before it starts checking.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
  typedef enum logic {
    MODE_INT  = 1'b0,
    MODE_FRAC = 1'b1
  } mul_mode_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/mac_rst_sync.sv
module mac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s_n = chain_q[STAGES-1];
endmodule

// File: rtl/mac_coef_reg.sv
module mac_coef_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_s_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] coef_q
);
  logic [DATA_W-1:0] coef_d;

  always_comb begin
    coef_d = din;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)  coef_q <= '0;
    else if (load) coef_q <= coef_d;
  end
endmodule

// File: rtl/mac_mult.sv
module mac_mult
  import frac_mac_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ACC_W  = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  mul_mode_e         mode,
  output logic [ACC_W-1:0]  prod
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic signed [PROD_W-1:0] a_x;
  logic signed [PROD_W-1:0] b_x;
  logic signed [PROD_W-1:0] full;
  logic        [PROD_W-1:0] sel;

  always_comb begin
    a_x  = {{DATA_W{a[DATA_W-1]}}, a};
    b_x  = {{DATA_W{b[DATA_W-1]}}, b};
    full = a_x * b_x;
    if (mode == MODE_FRAC) sel = {full[PROD_W-2:0], 1'b0};
    else                   sel = full;
  end

  generate
    if (ACC_W > PROD_W) begin : g_ext
      assign prod = {{(ACC_W-PROD_W){sel[PROD_W-1]}}, sel};
    end else begin : g_same
      assign prod = sel[ACC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_s_n,
  input  logic             clr,
  input  logic             valid,
  input  logic [ACC_W-1:0] term,
  output logic [ACC_W-1:0] acc_q
);
  logic [ACC_W-1:0] acc_d;
  logic             acc_en;

  always_comb begin
    acc_en = clr | valid;
    if (clr) acc_d = '0;
    else     acc_d = acc_q + term;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)    acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end
endmodule

// File: rtl/frac_mac.sv
module frac_mac
  import frac_mac_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coef_load,
  input  logic [DATA_W-1:0] coef_in,
  input  logic              frac_mode,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_in,
  input  logic              clr,
  output logic [ACC_W-1:0]  acc_out
);
  logic              rst_s_n;
  logic [DATA_W-1:0] coef_q;
  logic [ACC_W-1:0]  term;
  mul_mode_e         mode;

  assign mode = mul_mode_e'(frac_mode);

  mac_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  mac_coef_reg #(.DATA_W(DATA_W)) u_coef (
    .clk     (clk),
    .rst_s_n (rst_s_n),
    .load    (coef_load),
    .din     (coef_in),
    .coef_q  (coef_q)
  );

  mac_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mult (
    .a    (smp_in),
    .b    (coef_q),
    .mode (mode),
    .prod (term)
  );

  mac_accum #(.ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst_s_n (rst_s_n),
    .clr     (clr),
    .valid   (smp_valid),
    .term    (term),
    .acc_q   (acc_out)
  );
endmodule

// File: rtl/frac_mac_chk.sv
module frac_mac_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ACC_W  = 16
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              coef_load,
  input logic [DATA_W-1:0] coef_in,
  input logic [DATA_W-1:0] coef_q,
  input logic              frac_mode,
  input logic              smp_valid,
  input logic [DATA_W-1:0] smp_in,
  input logic              clr,
  input logic [ACC_W-1:0]  acc_out
);
  logic signed [ACC_W-1:0] sa;
  logic signed [ACC_W-1:0] sb;
  logic        [ACC_W-1:0] p_int;
  logic        [ACC_W-1:0] p_frac;

  assign sa     = {{(ACC_W-DATA_W){smp_in[DATA_W-1]}}, smp_in};
  assign sb     = {{(ACC_W-DATA_W){coef_q[DATA_W-1]}}, coef_q};
  assign p_int  = sa * sb;
  assign p_frac = {p_int[ACC_W-2:0], 1'b0};

  p_int_sum_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (smp_valid && !clr && !frac_mode) |=> acc_out == ACC_W'($past(acc_out) + $past(p_int)));

  p_frac_sum_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    (smp_valid && !clr && frac_mode) |=> acc_out == ACC_W'($past(acc_out) + $past(p_frac)));

  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    clr |=> acc_out == '0);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!smp_valid && !clr) |=> $stable(acc_out));

  p_coef_hold_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !coef_load |=> $stable(coef_q));

  p_coef_cap_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    coef_load |=> coef_q == $past(coef_in));
endmodule

bind frac_mac frac_mac_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .coef_load (coef_load),
  .coef_in   (coef_in),
  .coef_q    (coef_q),
  .frac_mode (frac_mode),
  .smp_valid (smp_valid),
  .smp_in    (smp_in),
  .clr       (clr),
  .acc_out   (acc_out)
);

// File: tb/sim_frac_mac.sv
`timescale 1ns/1ps
module sim_frac_mac;
  logic        clk;
  logic        rst_n;
  logic        coef_load;
  logic [7:0]  coef_in;
  logic        frac_mode;
  logic        smp_valid;
  logic [7:0]  smp_in;
  logic        clr;
  logic [15:0] acc_out;

  int          n_chk;
  int          n_err;
  logic [15:0] exp_acc;
  logic [7:0]  coef_m;
  logic        done;

  frac_mac u0 (
    .clk(clk), .rst_n(rst_n), .coef_load(coef_load), .coef_in(coef_in),
    .frac_mode(frac_mode), .smp_valid(smp_valid), .smp_in(smp_in),
    .clr(clr), .acc_out(acc_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] term_f(input logic [7:0] a, input logic [7:0] b,
                                         input logic m);
    int ia;
    int ib;
    int p;
    ia = int'($signed(a));
    ib = int'($signed(b));
    p  = ia * ib;
    if (m) p = p * 2;
    return p[15:0];
  endfunction

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: acc_out=%h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [7:0] a, input logic m, input logic c,
                     input logic ld, input logic [7:0] cin, input string req);
    @(negedge clk);
    smp_valid = v; smp_in = a; frac_mode = m; clr = c; coef_load = ld; coef_in = cin;
    @(posedge clk);
    if (c)      exp_acc = 16'h0000;
    else if (v) exp_acc = exp_acc + term_f(a, coef_m, m);
    if (ld) coef_m = cin;
    #1;
    check(acc_out, exp_acc, req);
  endtask

  initial begin
    done = 1'b0;
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: acc_out=%h expected run end", acc_out);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; exp_acc = '0; coef_m = '0;
    rst_n = 1'b0; coef_load = 0; coef_in = 0; frac_mode = 0;
    smp_valid = 0; smp_in = 0; clr = 0;
    repeat (3) @(negedge clk);
    check(acc_out, 16'h0000, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(acc_out, 16'h0000, "R1 after reset");
    // R1: held coefficient is zero after reset
    cyc(1, 8'h55, 0, 0, 0, 8'h00, "R1 zero coef");

    // R4: fractional (-1)*(-1) wraps to 0x8000, twice gives 0 (R5)
    cyc(0, 8'h00, 0, 0, 1, 8'h80, "R8 load");
    cyc(1, 8'h80, 1, 0, 0, 8'h00, "R4 frac wrap");
    check(acc_out, 16'h8000, "R4 literal");
    cyc(1, 8'h80, 1, 0, 0, 8'h00, "R5 wrap to zero");
    check(acc_out, 16'h0000, "R5 literal");

    // R5: integer accumulation passes 0x7FFF
    cyc(0, 8'h00, 0, 0, 1, 8'h7F, "R8 load 7F");
    for (int i = 0; i < 3; i++) cyc(1, 8'h7F, 0, 0, 0, 8'h00, "R5 int overflow");
    check(acc_out, 16'hBD03, "R5 literal");

    // R7: idle cycles with moving inputs
    for (int i = 0; i < 6; i++) cyc(0, 8'(i * 37), 1'(i), 0, 0, 8'h00, "R7 idle hold");

    // R6: clear beats valid
    cyc(1, 8'h40, 0, 1, 0, 8'h00, "R6 clear priority");
    check(acc_out, 16'h0000, "R6 literal");

    // R8: load with valid uses old coef (0x7F), new (0x02) afterwards
    cyc(1, 8'h02, 0, 0, 1, 8'h02, "R8 old coef");
    check(acc_out, 16'h00FE, "R8 literal old");
    cyc(1, 8'h03, 0, 0, 0, 8'h00, "R8 new coef");
    check(acc_out, 16'h0104, "R8 literal new");

    // R2/R3: sweep all coefficients, strided samples, mixed modes
    for (int c = 0; c < 256; c++) begin
      cyc(0, 8'h00, 0, 1, 1, 8'(c), "R6 clear before sweep");
      for (int s = 0; s < 256; s += 9) begin
        logic m;
        m = 1'((s / 9 + c) & 1);
        cyc(1, 8'(s), m, 0, 0, 8'h00, m ? "R3 frac sweep" : "R2 int sweep");
      end
      cyc(0, 8'hFF, 1, 0, 0, 8'h00, "R7 idle in sweep");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule